// File: doc/BRIEF.md
# SIMD Saturating Narrow Unit

This block halves the width of every element of a packed 128-bit source value and clamps each one into the narrower range, so that a value too large or too small for the destination element is pinned to the nearest limit instead of wrapping. The element interpretation is either two's complement or unsigned. The destination element width is 8, 16 or 32 bits, and each source element is twice as wide.

In vector form every lane of the source is narrowed into a 64-bit result. A half-select input decides where that result lands. When it is low, the result goes into the low half of the destination and the high half is zeroed. When it is high, the result goes into the high half and the low half keeps the current destination value. In scalar form a single element taken from the bottom of the source is narrowed into the lowest element slot, and every other destination bit is zero.

A 32-bit status register carries a sticky saturation flag. That flag is set whenever any narrowed element clamps. The results appear one clock after the valid strobe.

Top module: `sat_narrow_unit`

## Requirements
- R1: The destination element width is 8, 16 or 32 bits for size code 0, 1 or 2, and each source element is twice that width. In vector form, source element e (bits e*2W upward) narrows into result element e (bits e*W upward) of the 64-bit result, across 64/W lanes.
- R2: In signed mode an element greater than 2^(W-1)-1 becomes 2^(W-1)-1, an element less than -2^(W-1) becomes -2^(W-1), and any other element passes through as its low W bits.
- R3: In unsigned mode an element greater than 2^W-1 becomes all ones, and any other element passes through as its low W bits.
- R4: In vector form with the half-select at 0, dst_out[63:0] takes the result and dst_out[127:64] is zero.
- R5: In vector form with the half-select at 1, dst_out[127:64] takes the result and dst_out[63:0] equals dst_cur[63:0].
- R6: In scalar form only the element in src_vec[2W-1:0] is narrowed. It lands in dst_out[W-1:0], all other destination bits are zero, and the half-select has no effect.
- R7: status_reg bit 27 is set after any operation in which a narrowed element clamped. In scalar form only the single narrowed element counts. All other status bits stay zero.
- R8: Reset clears dst_out, enc_err and status_reg to zero. Once set, bit 27 stays set through operations that do not clamp, until the next reset.
- R9: Size code 3 is reserved. It raises enc_err for one cycle and leaves dst_out and status_reg unchanged.
- R10: The outputs update on the clock edge that samples in_valid high. Without in_valid, dst_out and status_reg hold and enc_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 128 | Source register value |
| dst_cur | input | 128 | Current destination value |
| size_code | input | 2 | Destination element width code (3 is reserved) |
| upper_half | input | 1 | Vector placement: 0 low half, 1 high half |
| signed_mode | input | 1 | 1 signed, 0 unsigned element reading |
| scalar_mode | input | 1 | 1 scalar form, 0 vector form |
| dst_out | output | 128 | Registered destination value |
| enc_err | output | 1 | Reserved size code seen on the previous strobe |
| status_reg | output | 32 | Status register, bit 27 is the sticky saturation flag |

## Verification
The checker follows the following behaviours on every cycle:
- The sticky flag never falls outside reset.
- A reserved size code freezes the destination and the status register and raises the error flag.
- Idle cycles hold the outputs.
- Half placement keeps or zeroes the correct destination half.
- A scalar byte narrow zeroes every bit above its element.

The actual clamped lane values, the mixed saturating and passing lane patterns, and the rule that the upper source lanes in scalar form cannot set the flag depend on data. Only the bench's table of vectors shows those, each vector starting from a fresh reset.

// File: rtl/sn_pkg.sv
package sn_pkg;

    localparam int VEC_W    = 128;
    localparam int HALF_W   = VEC_W / 2;
    localparam int STAT_W   = 32;
    localparam int SAT_POS  = 27;
    localparam int N_SIZES  = 3;
    localparam int SIZE_W   = 2;
    localparam int BASE_EW  = 8;

    typedef enum logic [SIZE_W-1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_S   = 2'd2,
        SZ_RSV = 2'd3
    } size_code_t;

    // One narrowed row: vector packing and scalar (lane 0 only) view
    typedef struct packed {
        logic [HALF_W-1:0] vec_res;
        logic [HALF_W-1:0] scl_res;
        logic              vec_sat;
        logic              scl_sat;
    } row_res_t;

    function automatic int elem_width(input int size_idx);
        return BASE_EW << size_idx;
    endfunction

    function automatic logic [STAT_W-1:0] sat_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        m[SAT_POS] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sn_lane_clamp.sv
module sn_lane_clamp #(
    parameter int OUT_W = 8
) (
    input  logic [2*OUT_W-1:0] src,
    input  logic               signed_mode,
    output logic [OUT_W-1:0]   res,
    output logic               sat
);
    logic [OUT_W:0]   top_bits;
    logic             sgn_fit;
    logic             uns_fit;
    logic [OUT_W-1:0] sgn_lim;

    always_comb begin
        top_bits = src[2*OUT_W-1:OUT_W-1];
        sgn_fit  = (top_bits == '0) || (top_bits == '1);
        uns_fit  = (src[2*OUT_W-1:OUT_W] == '0);
        sgn_lim  = {src[2*OUT_W-1], {(OUT_W-1){~src[2*OUT_W-1]}}};
        if (signed_mode) begin
            res = sgn_fit ? src[OUT_W-1:0] : sgn_lim;
            sat = ~sgn_fit;
        end else begin
            res = uns_fit ? src[OUT_W-1:0] : '1;
            sat = ~uns_fit;
        end
    end
endmodule

// File: rtl/sn_lane_row.sv
module sn_lane_row
    import sn_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic             signed_mode,
    output row_res_t         row
);
    localparam int LANES = HALF_W / OUT_W;

    logic [HALF_W-1:0] packed_res;
    logic [LANES-1:0]  lane_sat;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        sn_lane_clamp #(.OUT_W(OUT_W)) u_clamp (
            .src         (src[e*2*OUT_W +: 2*OUT_W]),
            .signed_mode (signed_mode),
            .res         (packed_res[e*OUT_W +: OUT_W]),
            .sat         (lane_sat[e])
        );
    end

    always_comb begin
        row.vec_res = packed_res;
        row.vec_sat = |lane_sat;
        row.scl_res = '0;
        row.scl_res[OUT_W-1:0] = packed_res[OUT_W-1:0];
        row.scl_sat = lane_sat[0];
    end
endmodule

// File: rtl/sn_place.sv
module sn_place
    import sn_pkg::*;
(
    input  row_res_t         row,
    input  logic             scalar_mode,
    input  logic             upper_half,
    input  logic [VEC_W-1:0] dst_cur,
    output logic [VEC_W-1:0] next_dst,
    output logic             any_sat
);
    logic [VEC_W-1:0] keep_low;
    logic [VEC_W-1:0] res_wide;

    always_comb begin
        keep_low = dst_cur & {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        res_wide = {{HALF_W{1'b0}}, row.vec_res};
        if (scalar_mode) begin
            next_dst = {{HALF_W{1'b0}}, row.scl_res};
            any_sat  = row.scl_sat;
        end else if (upper_half) begin
            next_dst = (res_wide << HALF_W) | keep_low;
            any_sat  = row.vec_sat;
        end else begin
            next_dst = res_wide;
            any_sat  = row.vec_sat;
        end
    end
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit
    import sn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [VEC_W-1:0]  dst_cur,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              upper_half,
    input  logic              signed_mode,
    input  logic              scalar_mode,
    output logic [VEC_W-1:0]  dst_out,
    output logic              enc_err,
    output logic [STAT_W-1:0] status_reg
);
    row_res_t          rows [N_SIZES];
    row_res_t          chosen;
    logic [VEC_W-1:0]  next_dst;
    logic              any_sat;
    logic              reserved;

    for (genvar k = 0; k < N_SIZES; k++) begin : g_row
        sn_lane_row #(.OUT_W(elem_width(k))) u_row (
            .src         (src_vec),
            .signed_mode (signed_mode),
            .row         (rows[k])
        );
    end

    always_comb begin
        reserved = (size_code_t'(size_code) == SZ_RSV);
        case (size_code_t'(size_code))
            SZ_B:    chosen = rows[0];
            SZ_H:    chosen = rows[1];
            SZ_S:    chosen = rows[2];
            default: chosen = '0;
        endcase
    end

    sn_place u_place (
        .row         (chosen),
        .scalar_mode (scalar_mode),
        .upper_half  (upper_half),
        .dst_cur     (dst_cur),
        .next_dst    (next_dst),
        .any_sat     (any_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_out    <= '0;
            enc_err    <= 1'b0;
            status_reg <= '0;
        end else begin
            enc_err <= in_valid && reserved;
            if (in_valid && !reserved) begin
                dst_out <= next_dst;
                if (any_sat) begin
                    status_reg <= status_reg | sat_mask();
                end
            end
        end
    end
endmodule

// File: rtl/sn_checker.sv
module sn_checker
    import sn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [VEC_W-1:0]  src_vec,
    input logic [VEC_W-1:0]  dst_cur,
    input logic [SIZE_W-1:0] size_code,
    input logic              upper_half,
    input logic              signed_mode,
    input logic              scalar_mode,
    input logic [VEC_W-1:0]  dst_out,
    input logic              enc_err,
    input logic [STAT_W-1:0] status_reg
);
    logic live;
    assign live = in_valid && (size_code != 2'd3);

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        status_reg[SAT_POS] |=> status_reg[SAT_POS]);

    // R9
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'd3) |=> (enc_err && $stable(dst_out) && $stable(status_reg)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!enc_err && $stable(dst_out) && $stable(status_reg)));

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !scalar_mode && upper_half) |=> (dst_out[HALF_W-1:0] == $past(dst_cur[HALF_W-1:0])));

    // R4
    lower_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (live && (scalar_mode || !upper_half)) |=> (dst_out[VEC_W-1:HALF_W] == '0));

    // R6
    scalar_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (live && scalar_mode && size_code == 2'd0) |=> (dst_out[VEC_W-1:BASE_EW] == '0));
endmodule

bind sat_narrow_unit sn_checker u_chk (.*);

// File: tb/sim_sat_narrow_unit.sv
`timescale 1ns/1ps
module sim_sat_narrow_unit;
    import sn_pkg::*;

    typedef struct packed {
        logic [31:0]  tag;
        logic [127:0] src;
        logic [127:0] cur;
        logic [1:0]   sz;
        logic         q;
        logic         sg;
        logic         sc;
        logic [127:0] exp;
        logic         sat;
    } vec_t;

    localparam vec_t TBL [11] = '{
        '{"R1", 128'h007F007F007F007F007F007F007F007F, {32{4'hA}}, 2'd0, 1'b0, 1'b1, 1'b0,
          128'h00000000000000007F7F7F7F7F7F7F7F, 1'b0},
        '{"R2", 128'hFF800080FF7F0001FFFF80007FFF0000, {32{4'hA}}, 2'd0, 1'b0, 1'b1, 1'b0,
          128'h0000000000000000807F8001FF807F00, 1'b1},
        '{"R3", 128'hFF800080FF7F0001FFFF80007FFF0000, {32{4'hA}}, 2'd0, 1'b0, 1'b0, 1'b0,
          128'h0000000000000000FF80FF01FFFFFF00, 1'b1},
        '{"R5", 128'h0000FFFF000100000000123400000000, 128'h11112222333344445555666677778888,
          2'd1, 1'b1, 1'b0, 1'b0, 128'hFFFFFFFF123400005555666677778888, 1'b1},
        '{"R5", 128'h00007FFFFFFF800000001234FFFFFFFE, 128'h11112222333344445555666677778888,
          2'd1, 1'b1, 1'b1, 1'b0, 128'h7FFF80001234FFFE5555666677778888, 1'b0},
        '{"R4", 128'h000000007FFFFFFFFFFFFFFF7FFFFFFF, {32{4'hC}}, 2'd2, 1'b0, 1'b1, 1'b0,
          128'h00000000000000007FFFFFFF80000000, 1'b1},
        '{"R4", 128'h00000000FFFFFFFF0000000000000005, {32{4'hC}}, 2'd2, 1'b0, 1'b0, 1'b0,
          128'h0000000000000000FFFFFFFF00000005, 1'b0},
        '{"R6", 128'h80008000800080008000800080000100, {32{4'hF}}, 2'd0, 1'b1, 1'b1, 1'b1,
          128'h0000000000000000000000000000007F, 1'b1},
        '{"R6", 128'hFFFFFFFFFFFFFFFFFFFFFFFF0000ABCD, {32{4'hF}}, 2'd1, 1'b0, 1'b0, 1'b1,
          128'h0000000000000000000000000000ABCD, 1'b0},
        '{"R6", 128'h0000000100000000FFFFFFFF80000000, {32{4'hF}}, 2'd2, 1'b1, 1'b1, 1'b1,
          128'h00000000000000000000000080000000, 1'b0},
        '{"R6", 128'hFFFFFFFFFFFFFFFF0000000100000000, {32{4'hF}}, 2'd2, 1'b0, 1'b0, 1'b1,
          128'h000000000000000000000000FFFFFFFF, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [VEC_W-1:0]  src_vec = '0;
    logic [VEC_W-1:0]  dst_cur = '0;
    logic [SIZE_W-1:0] size_code = '0;
    logic              upper_half = 1'b0;
    logic              signed_mode = 1'b0;
    logic              scalar_mode = 1'b0;
    logic [VEC_W-1:0]  dst_out;
    logic              enc_err;
    logic [STAT_W-1:0] status_reg;

    int n_checks = 0;
    int n_fails  = 0;
    logic [VEC_W-1:0] held;

    localparam logic [31:0] SAT_SET = 32'h0800_0000;

    always #4 clk = ~clk;

    sat_narrow_unit u0 (.*);

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [127:0] s, input logic [127:0] c, input logic [1:0] z,
                         input logic q, input logic sg, input logic sc);
        src_vec = s; dst_cur = c; size_code = z;
        upper_half = q; signed_mode = sg; scalar_mode = sc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R8 reset state
        check("R8 dst reset", dst_out, '0);
        check("R8 err reset", {127'b0, enc_err}, '0);
        check("R8 status reset", {96'b0, status_reg}, '0);

        for (int i = 0; i < 11; i++) begin
            do_reset();
            issue(TBL[i].src, TBL[i].cur, TBL[i].sz, TBL[i].q, TBL[i].sg, TBL[i].sc);
            check($sformatf("%s dst vec%0d", TBL[i].tag, i), dst_out, TBL[i].exp);
            check($sformatf("R7 status vec%0d", i), {96'b0, status_reg},
                  {96'b0, TBL[i].sat ? SAT_SET : 32'h0});
        end

        // R8 stickiness: clamp then a clean operation
        do_reset();
        issue(128'h0100, '0, 2'd0, 1'b0, 1'b1, 1'b1);
        issue(128'h0005, '0, 2'd0, 1'b0, 1'b1, 1'b1);
        check("R8 sticky status", {96'b0, status_reg}, {96'b0, SAT_SET});
        check("R1 clean after clamp", dst_out, 128'h05);

        // R9 reserved size keeps destination and status
        held = dst_out;
        issue({32{4'h8}}, {32{4'h3}}, 2'd3, 1'b1, 1'b1, 1'b0);
        check("R9 err raised", {127'b0, enc_err}, 128'h1);
        check("R9 dst unchanged", dst_out, held);
        check("R9 status unchanged", {96'b0, status_reg}, {96'b0, SAT_SET});

        // R10 idle cycle: error drops, outputs hold
        @(negedge clk);
        check("R10 err cleared", {127'b0, enc_err}, '0);
        check("R10 dst held", dst_out, held);

        // R8 reset clears sticky flag
        do_reset();
        check("R8 status cleared by reset", {96'b0, status_reg}, '0);

        // R9 reserved size on a clean status does not set the flag
        issue({32{4'hF}}, '0, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R9 no flag on reserved", {96'b0, status_reg}, '0);
        check("R9 dst stays reset value", dst_out, '0);

        finish_run();
    end
endmodule